// File: doc/BRIEF.md
# Watchdog and Interval Timer

An 8-bit up-counter advanced by a divided version of the peripheral clock. It runs in one of two modes. As a periodic interval timer, each overflow sets a sticky flag and raises an interrupt request, and counting carries on. As a watchdog, each overflow produces a reset pulse of fixed length, which an external reset generator consumes. Software writes a start value into the counter, chooses the mode and the count clock, and then sets the enable bit.

The count clock comes from a free-running prescaler that is never cleared by software. The first increment after enabling, or after a counter write, can therefore come anywhere from one to one full divided period later. Overflow is declared when the counter reaches all-ones, not when it wraps. Writing all-ones into a running counter therefore gives an overflow at once.

Top module: `tick_guard_timer`

## Requirements
- R1: After reset, both registers read 8'h00, and `irq_o` and `wd_reset_o` are low.
- R2: Register addresses and fields. Address 0 is control/status: bit 7 selects the mode (0 interval, 1 watchdog), bit 6 is the enable, bit 5 is the overflow flag, bits 2:0 are the clock select, and bits 4:3 read as 0. Address 1 is the counter, and it can be written and read. Read data appears on `bus_rdata` one clock after the cycle in which `bus_rd` is high.
- R3: While the enable bit is 0 the counter holds its value.
- R4: With default parameters, clock select values 0 to 7 divide the peripheral clock by 1, 2, 4, 8, 16, 32, 64 and 256. The first increment after enabling comes 1 to div cycles later, and each later increment comes exactly div cycles after the one before.
- R5: In interval mode, the counter reaching 8'hFF sets the flag and raises `irq_o` one clock later. After a preload P (P below 8'hFF), the edge at which the enable is written is followed by `irq_o` going high after T cycles, where (254-P)*div+2 <= T <= (255-P)*div+1.
- R6: In interval mode the counter keeps running after an overflow, and successive overflows are exactly 256*div cycles apart.
- R7: Writing 8'hFF to the counter while the timer is enabled gives an overflow one clock later, whatever the clock select value.
- R8: The flag stays set until software writes 0 to bit 5. Writing 1 to bit 5 never sets it. `irq_o` is high exactly when the flag is set and the mode is interval.
- R9: In watchdog mode an overflow drives `wd_reset_o` high for RST_CYCLES consecutive clocks (default 4), starting one clock after the counter reaches 8'hFF. The flag and `irq_o` stay low.
- R10: A counter write in the same cycle as a count tick wins: the counter takes the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 1 | Register select: 0 control/status, 1 counter |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| irq_o | output | 1 | Interval interrupt request (level) |
| wd_reset_o | output | 1 | Watchdog reset pulse |

## Verification
The assertions check on every cycle that:
- a counter write always sets the counter to the written value, even against a tick;
- a disabled counter never moves;
- an enabled counter moves by at most one per cycle;
- an interval overflow always sets the flag;
- the flag never drops without a control write;
- the reset pulse only starts after a watchdog overflow.

The bench's scenarios alone can show the timing windows that come from the free-running prescaler, the exact 256*div spacing of repeated overflows, the immediate overflow on an all-ones write, and the exact length of the reset pulse. The same holds for the gating of the interrupt by mode.

// File: rtl/tgt_pkg.sv
package tgt_pkg;
  localparam int DATA_W = 8;
  localparam int SEL_W  = 3;
  localparam int NSEL   = 1 << SEL_W;

  localparam int BIT_MODE = 7;
  localparam int BIT_EN   = 6;
  localparam int BIT_FLAG = 5;

  localparam logic [DATA_W-1:0] CNT_TOP = {DATA_W{1'b1}};

  typedef enum logic {
    ADDR_CTRL = 1'b0,
    ADDR_CNT  = 1'b1
  } reg_addr_e;
endpackage

// File: rtl/tgt_prescaler.sv
module tgt_prescaler
  import tgt_pkg::*;
#(
  parameter int          PRESC_W  = 8,
  parameter logic [31:0] DIV_LOG2 = 32'h8654_3210
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  logic [PRESC_W-1:0] presc;
  logic [NSEL-1:0]    tick_vec;

  always_ff @(posedge clk) begin
    if (rst) presc <= '0;
    else     presc <= presc + 1'b1;
  end

  for (genvar k = 0; k < NSEL; k++) begin : g_tap
    localparam int unsigned SH = int'(DIV_LOG2[4*k +: 4]);
    localparam logic [PRESC_W-1:0] MASK = PRESC_W'((32'd1 << SH) - 32'd1);
    assign tick_vec[k] = ((presc & MASK) == MASK);
  end

  assign tick = tick_vec[sel];
endmodule

// File: rtl/tgt_counter.sv
module tgt_counter
  import tgt_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              tick,
  input  logic              wr_cnt,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] cnt,
  output logic              ovf_pulse
);
  logic hit;
  logic hit_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (wr_cnt) begin
      cnt <= wdata;
    end else if (en && tick) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign hit = en && (cnt == CNT_TOP);

  always_ff @(posedge clk) begin
    if (rst) hit_q <= 1'b0;
    else     hit_q <= hit;
  end

  assign ovf_pulse = hit && !hit_q;

  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (rst)
    wr_cnt |=> cnt == $past(wdata)); // R10

  AST_HOLD_DISABLED: assert property (@(posedge clk) disable iff (rst)
    (!en && !wr_cnt) |=> $stable(cnt)); // R3

  AST_STEP_ONE: assert property (@(posedge clk) disable iff (rst)
    (en && !wr_cnt) |=> (cnt == $past(cnt) || cnt == $past(cnt) + 8'd1)); // R4
endmodule

// File: rtl/tgt_ctrl.sv
module tgt_ctrl
  import tgt_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_ctrl,
  input  logic              rd_en,
  input  logic              rd_addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] cnt,
  input  logic              ovf_pulse,
  output logic              mode,
  output logic              en,
  output logic [SEL_W-1:0]  sel,
  output logic              irq_o,
  output logic [DATA_W-1:0] rdata
);
  logic             flag;
  logic             flag_d;
  logic             mode_d;
  logic             en_d;
  logic [SEL_W-1:0] sel_d;
  logic             unused_bits;

  assign unused_bits = ^wdata[BIT_FLAG-1:SEL_W];

  always_comb begin
    mode_d = mode;
    en_d   = en;
    sel_d  = sel;
    flag_d = flag;
    if (wr_ctrl) begin
      mode_d = wdata[BIT_MODE];
      en_d   = wdata[BIT_EN];
      sel_d  = wdata[SEL_W-1:0];
      if (!wdata[BIT_FLAG]) flag_d = 1'b0;
    end
    if (ovf_pulse && !mode) flag_d = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode  <= 1'b0;
      en    <= 1'b0;
      sel   <= '0;
      flag  <= 1'b0;
      irq_o <= 1'b0;
    end else begin
      mode  <= mode_d;
      en    <= en_d;
      sel   <= sel_d;
      flag  <= flag_d;
      irq_o <= flag_d && !mode_d;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd_en) begin
      if (rd_addr == ADDR_CNT) rdata <= cnt;
      else rdata <= {mode, en, flag, {(BIT_FLAG-SEL_W){1'b0}}, sel};
    end
  end

  AST_FLAG_SET: assert property (@(posedge clk) disable iff (rst)
    (ovf_pulse && !mode) |=> flag); // R5

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    (flag && !wr_ctrl) |=> flag); // R8
endmodule

// File: rtl/tgt_reset_pulse.sv
module tgt_reset_pulse #(
  parameter int RST_CYCLES = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic trig,
  output logic wd_reset_o
);
  localparam int RW = $clog2(RST_CYCLES + 1);

  logic [RW-1:0] remain;

  always_ff @(posedge clk) begin
    if (rst) begin
      wd_reset_o <= 1'b0;
      remain     <= '0;
    end else if (trig) begin
      wd_reset_o <= 1'b1;
      remain     <= RW'(RST_CYCLES - 1);
    end else if (remain != '0) begin
      remain <= remain - 1'b1;
    end else begin
      wd_reset_o <= 1'b0;
    end
  end

  AST_RST_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $rose(wd_reset_o) |-> $past(trig)); // R9
endmodule

// File: rtl/tick_guard_timer.sv
module tick_guard_timer
  import tgt_pkg::*;
#(
  parameter int          PRESC_W    = 8,
  parameter logic [31:0] DIV_LOG2   = 32'h8654_3210,
  parameter int          RST_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_o,
  output logic              wd_reset_o
);
  logic              mode;
  logic              en;
  logic [SEL_W-1:0]  sel;
  logic              tick;
  logic [DATA_W-1:0] cnt;
  logic              ovf_pulse;
  logic              wr_cnt;
  logic              wr_ctrl;

  assign wr_cnt  = bus_wr && (bus_addr == ADDR_CNT);
  assign wr_ctrl = bus_wr && (bus_addr == ADDR_CTRL);

  tgt_prescaler #(.PRESC_W(PRESC_W), .DIV_LOG2(DIV_LOG2)) u_presc (
    .clk(clk), .rst(rst), .sel(sel), .tick(tick)
  );

  tgt_counter u_cnt (
    .clk(clk), .rst(rst), .en(en), .tick(tick), .wr_cnt(wr_cnt),
    .wdata(bus_wdata), .cnt(cnt), .ovf_pulse(ovf_pulse)
  );

  tgt_ctrl u_ctrl (
    .clk(clk), .rst(rst), .wr_ctrl(wr_ctrl), .rd_en(bus_rd),
    .rd_addr(bus_addr), .wdata(bus_wdata), .cnt(cnt), .ovf_pulse(ovf_pulse),
    .mode(mode), .en(en), .sel(sel), .irq_o(irq_o), .rdata(bus_rdata)
  );

  tgt_reset_pulse #(.RST_CYCLES(RST_CYCLES)) u_rst (
    .clk(clk), .rst(rst), .trig(ovf_pulse && mode), .wd_reset_o(wd_reset_o)
  );

  AST_NO_IRQ_WD: assert property (@(posedge clk) disable iff (rst)
    (ovf_pulse && mode) |=> !irq_o || $past(irq_o)); // R9
endmodule

// File: tb/test_tick_guard_timer.sv
module test_tick_guard_timer;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_addr = 1'b0;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       irq_o;
  logic       wd_reset_o;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  tick_guard_timer i_tick_guard_timer (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_o(irq_o), .wd_reset_o(wd_reset_o)
  );

  function automatic int div_of(input int s);
    int sh [8] = '{0, 1, 2, 3, 4, 5, 6, 8};
    return 1 << sh[s];
  endfunction

  function automatic int t_lo(input int p, input int d);
    return (254 - p) * d + 2;
  endfunction

  function automatic int t_hi(input int p, input int d);
    return (255 - p) * d + 1;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // called at a falling edge, returns at the next falling edge
  task automatic wr(input bit a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input bit a, output logic [7:0] d);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  // cycles until irq_o is seen high, counted from the last write edge
  task automatic wait_irq(output int n);
    n = 0;
    do begin
      @(posedge clk); #1; n++;
    end while (!irq_o && n < 5000);
    @(negedge clk);
  endtask

  initial begin
    #600000;
    n_bad++;
    $display("FAIL watchdog timeout actual=1 expected=0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] v;
    int n, m, s, p, d, hi_len;
    bit irq_seen;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    rd(1'b0, v); chk(v == 8'h00, "R1 ctrl", v, 0);
    rd(1'b1, v); chk(v == 8'h00, "R1 cnt", v, 0);
    chk(!irq_o && !wd_reset_o, "R1 outputs", {irq_o, wd_reset_o}, 0);

    // R2 field readback, reserved bits read 0
    wr(1'b0, 8'h1D);
    rd(1'b0, v); chk(v == 8'h05, "R2 ctrl layout", v, 8'h05);
    wr(1'b1, 8'h5A);
    rd(1'b1, v); chk(v == 8'h5A, "R2 cnt readback", v, 8'h5A);

    // R3 disabled counter holds
    repeat (50) @(negedge clk);
    rd(1'b1, v); chk(v == 8'h5A, "R3 hold", v, 8'h5A);

    // R10 write beats tick (select 0 ticks every cycle)
    wr(1'b0, 8'h40);
    repeat (5) @(negedge clk);
    wr(1'b1, 8'h30);
    rd(1'b1, v); chk(v == 8'h30, "R10 write priority", v, 8'h30);
    wr(1'b0, 8'h00);

    // R4 R5 R6 random preload and select
    for (int it = 0; it < 8; it++) begin
      s = $urandom_range(0, 2);
      p = $urandom_range(0, 250);
      d = div_of(s);
      wr(1'b0, 8'h00);
      wr(1'b1, 8'(p));
      wr(1'b0, 8'h40 | 8'(s));
      wait_irq(n);
      chk(n >= t_lo(p, d) && n <= t_hi(p, d), "R5 first overflow time", n, t_lo(p, d));
      chk(n >= t_lo(p, d) && n <= t_hi(p, d), "R4 first tick window", n, t_hi(p, d));
      wr(1'b0, 8'h40 | 8'(s));
      wait_irq(m);
      chk(m + 1 == 256 * d, "R6 overflow period", m + 1, 256 * d);
    end

    // R7 all-ones write overflows at once even with slowest select
    wr(1'b0, 8'h00);
    wr(1'b1, 8'h00);
    wr(1'b0, 8'h47);
    wr(1'b1, 8'hFF);
    n = 0;
    @(posedge clk); #1; n++;
    chk(irq_o == 1'b1, "R7 immediate overflow", irq_o, 1);
    @(negedge clk);

    // R8 flag sticky, gated by mode, not set by writing 1
    repeat (20) @(negedge clk);
    chk(irq_o == 1'b1, "R8 flag sticky", irq_o, 1);
    wr(1'b0, 8'hA0);
    chk(irq_o == 1'b0, "R8 irq gated by mode", irq_o, 0);
    rd(1'b0, v); chk(v == 8'hA0, "R8 flag kept", v, 8'hA0);
    wr(1'b0, 8'h00);
    chk(irq_o == 1'b0, "R8 flag cleared", irq_o, 0);
    wr(1'b0, 8'h20);
    rd(1'b0, v); chk(v == 8'h00, "R8 write 1 no set", v, 0);

    // R9 watchdog reset pulse
    wr(1'b0, 8'h80);
    wr(1'b1, 8'hFE);
    wr(1'b0, 8'hC0);
    n = 0; irq_seen = 1'b0;
    do begin
      @(posedge clk); #1; n++;
      if (irq_o) irq_seen = 1'b1;
    end while (!wd_reset_o && n < 100);
    chk(n == 2, "R9 reset start", n, 2);
    hi_len = 0;
    while (wd_reset_o && hi_len < 100) begin
      hi_len++;
      @(posedge clk); #1;
      if (irq_o) irq_seen = 1'b1;
    end
    chk(hi_len == 4, "R9 reset length", hi_len, 4);
    chk(!irq_seen, "R9 no irq", irq_seen, 0);
    @(negedge clk);
    wr(1'b0, 8'h80);
    rd(1'b0, v); chk(v[5] == 1'b0, "R9 flag clear", v[5], 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule